// File: doc/BRIEF.md
# Cascaded Event Counter with Selectable Count Source

This block is an up-counter made of two equal halves. In the default joined mode the low half carries into the high half, so together they form one counter twice the width of a half. Each count comes from one of four sources: the system clock divided by 2, 4 or 8 from a free-running prescaler, or edges on an asynchronous event pin. For the pin, software picks falling, rising or both edges. A gate input must be high for any count to land.

When the joined counter steps past its all-ones value, it returns to zero and keeps counting. The same step sets a sticky overflow flag and an interrupt request flag. The interrupt output follows the request only while software has enabled it. Software reaches every field through a plain synchronous register bus. The bus has no back-pressure: a write or read strobe is taken on the same clock edge, and a read returns its data one cycle later. Each half has its own run bit and its own keep bit. Software clears both bits, clears the flags, then sets both bits to start counting from zero.

Top module: `evt_cascade_counter`

## Requirements
- R1: After reset every register field reads 0: joined mode, source code 00 (event pin), edge code 00 (falling), run and keep bits off, flags and interrupt enable clear, both halves zero, and the interrupt output low.
- R2: Source codes in CTRL (address 0) bits [2:1] select the count tick: 01 gives one tick every 2 system clocks, 10 every 4, 11 every 8, and 00 selects the event pin.
- R3: With the pin selected, the edge code in CTRL bits [4:3] selects the edges that count: 00 counts falling edges, 01 rising, 10 both, and 11 behaves as 00. The pin passes through a two-flop synchronizer before edge detection.
- R4: While the gate input is low, no tick from any source changes the count.
- R5: In RUN (address 1), bit 0 is the low run bit, bit 1 the high run bit, bit 2 the low keep bit and bit 3 the high keep bit. A keep bit at 0 holds its half at zero. A run bit at 0 freezes its half at its present value.
- R6: With the CTRL bit 0 mode bit at 0, the high half advances only when the low half steps from all-ones to zero. The low half reads at address 3 and the high half at address 4, zero-extended.
- R7: A tick taken at the joined all-ones value wraps both halves to zero and sets the overflow flag (FLAGS, address 2, bit 0) and the request flag (FLAGS bit 1). Counting then continues.
- R8: The interrupt output equals the request flag ANDed with the enable bit (FLAGS bit 2, read/write).
- R9: The overflow and request flags clear only when 0 is written to their bit. Writing 1 leaves them unchanged. A new overflow in the same cycle as a clearing write leaves the flag set.
- R10: With the mode bit at 1, the halves do not carry. Each half advances on every accepted tick, and no overflow flag is raised.
- R11: Writes take effect at the strobe's clock edge. Read data is registered and is valid in the cycle after the read strobe. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| gate_i | input | 1 | Count gate; counting only while high |
| evt_pin_i | input | 1 | Asynchronous event pin |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request output |

## Verification
The bench builds the block with HALF_W = 4, which makes the joined counter eight bits wide. The all-ones wrap and the carry from the low half into the high half are then reached after 256 and 16 ticks, well inside the run time. The bench drives exact counts of pin edges for every edge code to test the wrap, the sticky flags and the interrupt mask. It measures the prescaler rates over random windows, and it checks that split mode counts both halves alike with no overflow.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    SRC_PIN  = 2'b00,
    SRC_DIV2 = 2'b01,
    SRC_DIV4 = 2'b10,
    SRC_DIV8 = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    EDG_FALL = 2'b00,
    EDG_RISE = 2'b01,
    EDG_BOTH = 2'b10,
    EDG_RSVD = 2'b11
  } edge_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_RUN  = 1;
  localparam int ADDR_FLAG = 2;
  localparam int ADDR_CLO  = 3;
  localparam int ADDR_CHI  = 4;

  localparam int NUM_TAPS  = 3;
endpackage

// File: rtl/evc_prescale.sv
module evc_prescale #(
  parameter int NUM_TAPS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [NUM_TAPS-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // tap k pulses once every 2^(k+1) cycles
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign tap_o[k] = &div_q[k:0];
  end
endmodule

// File: rtl/evc_edge_detect.sv
module evc_edge_detect
  import evc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_i,
  input  edge_e edge_sel_i,
  output logic  hit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

  always_comb begin
    unique case (edge_sel_i)
      EDG_RISE: hit_o = rise;
      EDG_BOTH: hit_o = rise | fall;
      default:  hit_o = fall;
    endcase
  end
endmodule

// File: rtl/evc_cascade.sv
module evc_cascade #(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              split_i,
  input  logic              lo_run_i,
  input  logic              hi_run_i,
  input  logic              lo_keep_i,
  input  logic              hi_keep_i,
  output logic [HALF_W-1:0] cnt_lo_o,
  output logic [HALF_W-1:0] cnt_hi_o,
  output logic              wrap_o
);
  logic lo_adv, lo_carry, hi_adv;

  assign lo_adv   = tick_i & lo_run_i & lo_keep_i;
  assign lo_carry = lo_adv & (&cnt_lo_o);
  assign hi_adv   = hi_run_i & hi_keep_i & (split_i ? tick_i : lo_carry);
  assign wrap_o   = ~split_i & lo_carry & hi_adv & (&cnt_hi_o);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        cnt_lo_o <= '0;
    else if (!lo_keep_i) cnt_lo_o <= '0;
    else if (lo_adv)     cnt_lo_o <= cnt_lo_o + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        cnt_hi_o <= '0;
    else if (!hi_keep_i) cnt_hi_o <= '0;
    else if (hi_adv)     cnt_hi_o <= cnt_hi_o + 1'b1;
  end
endmodule

// File: rtl/evt_cascade_counter.sv
module evt_cascade_counter
  import evc_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic              evt_pin_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic                split_q;
  src_e                src_q;
  edge_e               edge_q;
  logic                lo_run_q, hi_run_q, lo_keep_q, hi_keep_q;
  logic                ovf_q, req_q, ien_q;
  logic [NUM_TAPS-1:0] taps;
  logic                pin_hit, src_tick, tick;
  logic [HALF_W-1:0]   cnt_lo, cnt_hi;
  logic                wrap;
  logic                wr_ctrl, wr_run, wr_flag;
  logic [DATA_W-1:0]   rd_val;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:5];

  evc_prescale #(.NUM_TAPS(NUM_TAPS)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tap_o (taps)
  );

  evc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (evt_pin_i),
    .edge_sel_i(edge_q),
    .hit_o     (pin_hit)
  );

  always_comb begin
    unique case (src_q)
      SRC_PIN:  src_tick = pin_hit;
      SRC_DIV2: src_tick = taps[0];
      SRC_DIV4: src_tick = taps[1];
      default:  src_tick = taps[2];
    endcase
  end

  assign tick = src_tick & gate_i;

  evc_cascade #(.HALF_W(HALF_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .split_i  (split_q),
    .lo_run_i (lo_run_q),
    .hi_run_i (hi_run_q),
    .lo_keep_i(lo_keep_q),
    .hi_keep_i(hi_keep_q),
    .cnt_lo_o (cnt_lo),
    .cnt_hi_o (cnt_hi),
    .wrap_o   (wrap)
  );

  assign wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_run  = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_RUN));
  assign wr_flag = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_FLAG));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      split_q <= 1'b0;
      src_q   <= SRC_PIN;
      edge_q  <= EDG_FALL;
    end else if (wr_ctrl) begin
      split_q <= bus_wdata_i[0];
      src_q   <= src_e'(bus_wdata_i[2:1]);
      edge_q  <= edge_e'(bus_wdata_i[4:3]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      {hi_keep_q, lo_keep_q, hi_run_q, lo_run_q} <= '0;
    end else if (wr_run) begin
      {hi_keep_q, lo_keep_q, hi_run_q, lo_run_q} <= bus_wdata_i[3:0];
    end
  end

  // flags: write 0 clears, write 1 ignored; a new wrap wins
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      req_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      ovf_q <= wrap | (ovf_q & ~(wr_flag & ~bus_wdata_i[0]));
      req_q <= wrap | (req_q & ~(wr_flag & ~bus_wdata_i[1]));
      if (wr_flag) ien_q <= bus_wdata_i[2];
    end
  end

  assign irq_o = req_q & ien_q;

  always_comb begin
    rd_val = '0;
    case (bus_addr_i)
      ADDR_W'(ADDR_CTRL): rd_val[4:0] = {edge_q, src_q, split_q};
      ADDR_W'(ADDR_RUN):  rd_val[3:0] = {hi_keep_q, lo_keep_q, hi_run_q, lo_run_q};
      ADDR_W'(ADDR_FLAG): rd_val[2:0] = {ien_q, req_q, ovf_q};
      ADDR_W'(ADDR_CLO):  rd_val[HALF_W-1:0] = cnt_lo;
      ADDR_W'(ADDR_CHI):  rd_val[HALF_W-1:0] = cnt_hi;
      default:            rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_val;
  end
endmodule

// File: rtl/evc_checker.sv
module evc_checker
  import evc_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                gate_i,
  input logic                split_i,
  input logic                lo_run_i,
  input logic                hi_run_i,
  input logic                lo_keep_i,
  input logic                hi_keep_i,
  input logic [2*HALF_W-1:0] cnt_i,
  input logic                ovf_i,
  input logic                req_i,
  input logic                ien_i,
  input logic                irq_i,
  input logic                bus_wr_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [DATA_W-1:0]   bus_wdata_i
);
  localparam int CW = 2 * HALF_W;

  AST_GATE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && lo_keep_i && hi_keep_i) |=> $stable(cnt_i)); // R4

  AST_KEEP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_keep_i |=> (cnt_i[HALF_W-1:0] == '0)); // R5

  AST_RUN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_run_i && !hi_run_i && lo_keep_i && hi_keep_i) |=> $stable(cnt_i)); // R5

  AST_JOINED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split_i && lo_keep_i && hi_keep_i && (cnt_i != '1))
      |=> (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + CW'(1))); // R6

  AST_WRAP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_i == '0) && ($past(cnt_i) == '1) && $past(!split_i && lo_keep_i && hi_keep_i))
      |-> (ovf_i && req_i)); // R7

  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i |-> !irq_i); // R8

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !(bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_FLAG)) && !bus_wdata_i[0]))
      |=> ovf_i); // R9

  AST_SPLIT_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && !ovf_i) |=> !ovf_i); // R10
endmodule

bind evt_cascade_counter evc_checker #(
  .HALF_W(HALF_W),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gate_i     (gate_i),
  .split_i    (split_q),
  .lo_run_i   (lo_run_q),
  .hi_run_i   (hi_run_q),
  .lo_keep_i  (lo_keep_q),
  .hi_keep_i  (hi_keep_q),
  .cnt_i      ({cnt_hi, cnt_lo}),
  .ovf_i      (ovf_q),
  .req_i      (req_q),
  .ien_i      (ien_q),
  .irq_i      (irq_o),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i)
);

// File: tb/evt_cascade_counter_tb.sv
module evt_cascade_counter_tb;
  localparam int HW  = 4;
  localparam int DW  = 8;
  localparam int AW  = 3;
  localparam int MOD = 1 << (2 * HW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gate = 1'b0;
  logic          pin = 1'b0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  evt_cascade_counter #(.HALF_W(HW), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .gate_i     (gate),
    .evt_pin_i  (pin),
    .bus_wr_i   (wr),
    .bus_rd_i   (rd),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .irq_o      (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input int act, input int exp);
    n_chk++;
    if (act < exp - 1 || act > exp + 1) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d(+/-1)", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk);
    rd = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd = 1'b0;
    d = int'(rdata);
  endtask

  task automatic read_count(output int v);
    int lo, hi;
    bus_read(3, lo);
    bus_read(4, hi);
    v = hi * (1 << HW) + lo;
  endtask

  task automatic restart(input int ctrl);
    bus_write(0, ctrl);
    bus_write(1, 32'h03);
    bus_write(2, 32'h00);
    bus_write(1, 32'h0F);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int edge_inc(input int mode, input bit rising);
    if (mode == 2) return 1;
    if (mode == 1) return rising ? 1 : 0;
    return rising ? 0 : 1;
  endfunction

  task automatic pulse();
    @(negedge clk); pin = 1'b1; settle(4);
    pin = 1'b0; settle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, v2, lo, hi, exp, mode, w, d;
    void'($urandom(32'd20240611));
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset defaults
    bus_read(0, v); chk("R1 ctrl", v, 0);
    bus_read(1, v); chk("R1 run", v, 0);
    bus_read(2, v); chk("R1 flags", v, 0);
    read_count(v);  chk("R1 count", v, 0);
    chk("R1 irq", int'(irq), 0);
    bus_read(6, v); chk("R11 unused addr", v, 0);

    // R3 default falling edge, directed
    gate = 1'b1;
    restart(0);
    @(negedge clk); pin = 1'b1; settle(5);
    read_count(v); chk("R3 falling ignores rise", v, 0);
    pin = 1'b0; settle(5);
    read_count(v); chk("R3 falling counts fall", v, 1);

    // R3/R4 random edge modes with random gate
    for (int it = 0; it < 16; it++) begin
      mode = int'($urandom_range(0, 3));
      gate = 1'(($urandom_range(0, 3)) != 0);
      restart(mode << 3);
      exp = 0;
      for (int p = 0; p < int'($urandom_range(1, 5)); p++) begin
        pulse();
        if (gate) exp += edge_inc(mode, 1'b1) + edge_inc(mode, 1'b0);
      end
      read_count(v);
      chk(gate ? "R3 edge mode count" : "R4 gate low no count", v, exp);
    end

    // R2 prescaler rates over random windows
    for (int it = 0; it < 9; it++) begin
      int code;
      code = (it % 3) + 1;
      d = 1 << code;
      w = int'($urandom_range(40, 120));
      gate = 1'b0;
      restart(code << 1);
      @(negedge clk); gate = 1'b1;
      settle(w);
      gate = 1'b0;
      settle(2);
      read_count(v);
      chk_near("R2 prescale rate / R6 carry", v, w / d);
    end

    // R4 gate low with fast source
    gate = 1'b0;
    restart(1 << 1);
    settle(40);
    read_count(v); chk("R4 gate low div2", v, 0);

    // R5 run freeze and keep hold
    gate = 1'b1;
    restart(1 << 1);
    settle(30);
    bus_write(1, 32'h0C);
    read_count(v); settle(20);
    read_count(v2); chk("R5 run off freezes", v2, v);
    bus_write(1, 32'h08);
    settle(2);
    bus_read(3, lo); chk("R5 keep off holds low at zero", lo, 0);
    bus_read(4, hi); chk("R5 high keeps value", hi, v / (1 << HW));

    // R6 exact cascade via pin edges
    restart(0);
    for (int p = 0; p < 17; p++) pulse();
    bus_read(3, lo); chk("R6 low half", lo, 1);
    bus_read(4, hi); chk("R6 high half carry", hi, 1);

    // R7 wrap, R8 mask, R9 sticky
    restart(0);
    for (int p = 0; p < MOD - 1; p++) pulse();
    read_count(v); chk("R7 all ones", v, MOD - 1);
    bus_read(2, v); chk("R7 no flag before wrap", v, 0);
    pulse();
    read_count(v); chk("R7 wrap to zero", v, 0);
    bus_read(2, v); chk("R7 flags set", v & 3, 3);
    chk("R8 irq masked", int'(irq), 0);
    bus_write(2, 32'h07);
    settle(1);
    chk("R8 irq enabled", int'(irq), 1);
    bus_read(2, v); chk("R9 write ones keeps flags", v, 7);
    pulse();
    read_count(v); chk("R7 keeps counting", v, 1);
    bus_write(2, 32'h04);
    bus_read(2, v); chk("R9 write zero clears", v, 4);
    chk("R8 irq drops", int'(irq), 0);

    // R10 split mode
    gate = 1'b0;
    restart(1 | (1 << 1));
    @(negedge clk); gate = 1'b1;
    settle(80);
    gate = 1'b0;
    settle(2);
    bus_read(3, lo); bus_read(4, hi);
    chk("R10 halves equal", hi, lo);
    chk_near("R10 low modulo", lo + ((lo < 4) ? 16 : 0), 8 + ((8 < 4) ? 16 : 0));
    bus_read(2, v); chk("R10 no overflow", v & 1, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule